// File: doc/BRIEF.md
# Stop Mode Sequencer

This block sequences the device's entry into and exit from its low-power stop states. When the processor executes its stop instruction, the block receives a requested depth (levels 1 to 3) and decides the depth that is actually entered. The decision takes into account whether the supply monitor must stay armed during stop and whether the debug port is enabled. It then drives the power-domain controls: regulator standby, the debug and peripheral clock gates, the high- and medium-frequency oscillator enables, pin hold and pin high-impedance, and a one-cycle ADC abort strobe.

A wake event brings the block back to run. That event is either an interrupt or a debug "enter background" command, and both pass through a synchronizer. On wake from the two deepest levels, the block issues a one-cycle register reset. Pins latched for level 2 stay held after wake until software writes a release acknowledge. A status output reports the depth the block last left. The low-frequency oscillator, the periodic wake-up unit and the wake-up timer clock are never gated here.

Top module: `stop_seq_ctrl`

## Requirements
- R1: The entered depth is decided at the stop request and held until wake. A request code of 1 or 2 selects that depth, and codes 3 and 0 select depth 3. If `dbg_en`, or both `lvd_en` and `lvd_stop_en`, are 1, any request is entered as depth 4. After wake, `exit_mode` shows the depth left (1 to 4); it reads 0 after reset.
- R2: While `in_stop` is 1, `periph_clk_en` and `hfo_en` are 0. In run both are 1.
- R3: While in stop, `dbg_clk_en` equals the value `dbg_en` had at the stop request. In run it is 1.
- R4: `reg_standby` is 1 in depths 1, 2 and 3. It is 0 in depth 4 and in run.
- R5: `pin_hiz` is 1 only in depth 1. `pin_hold` goes to 1 on entry to depth 2 and remains 1 after wake until `pin_ack` is 1 in run. `pin_ack` during stop has no effect.
- R6: Wake from depth 1 or 2 gives exactly one `sys_reset` cycle. Wake from depth 3 or 4 gives none.
- R7: Wake inputs pass through a two-flop synchronizer, so stop ends on the third rising edge after the wake input rises. `wake_dbg` wakes the block only when debug was enabled at the stop request, and that wake gives one `bkgd_enter` cycle.
- R8: In the cycle between the stop request and the stop state, `adc_abort` is 1 for depth 3 or 4 when `adc_async_clk` is 0. It is 0 otherwise.
- R9: While in stop, `mfo_en` equals `mfo_need`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop instruction executed (one cycle) |
| req_level | input | 2 | Requested depth code |
| lvd_en | input | 1 | Supply monitor enabled |
| lvd_stop_en | input | 1 | Supply monitor kept in stop |
| dbg_en | input | 1 | Debug port enabled |
| wake_irq | input | 1 | Asynchronous wake interrupt |
| wake_dbg | input | 1 | Asynchronous debug enter-background command |
| pin_ack | input | 1 | Software pin release acknowledge |
| adc_async_clk | input | 1 | ADC runs from its own asynchronous clock |
| mfo_need | input | 1 | Receiver sampling or measurement pending |
| in_stop | output | 1 | Block is in a stop state |
| reg_standby | output | 1 | Regulator in standby |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| hfo_en | output | 1 | High-frequency oscillator enable |
| mfo_en | output | 1 | Medium-frequency oscillator enable |
| pin_hold | output | 1 | Pin states latched |
| pin_hiz | output | 1 | Pins forced high-impedance |
| adc_abort | output | 1 | ADC conversion abort strobe |
| sys_reset | output | 1 | Register reset pulse on wake |
| bkgd_enter | output | 1 | Enter background debug pulse |
| exit_mode | output | 3 | Depth last exited |

## Verification
The hardest case to reach is a debug command that arrives while debug was disabled at the stop request. That command must leave the block in stop, and a later interrupt must still wake it without a background pulse. The stimulus reaches this by holding `wake_dbg` for several cycles inside stop before raising `wake_irq`. It also exercises software acknowledges sent during depth 2, which must not release the pins. Random enable and level combinations cover all four depths together with both ADC clock choices.

// File: rtl/stop_pkg.sv
package stop_pkg;

    typedef enum logic [2:0] {
        MODE_NONE = 3'd0,
        MODE_S1   = 3'd1,
        MODE_S2   = 3'd2,
        MODE_S3   = 3'd3,
        MODE_S4   = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_ENTER = 3'd1,
        ST_STOP1 = 3'd2,
        ST_STOP2 = 3'd3,
        ST_STOP3 = 3'd4,
        ST_STOP4 = 3'd5,
        ST_WAKE  = 3'd6
    } state_e;

    typedef struct packed {
        logic reg_standby;
        logic dbg_clk_en;
        logic periph_clk_en;
        logic hfo_en;
        logic mfo_en;
        logic pin_hiz;
        logic adc_abort;
        logic sys_reset;
        logic bkgd_enter;
    } pm_ctrl_t;

    // Requested code to effective depth; keep_reg forces full regulation
    function automatic mode_e resolve_mode(input logic [1:0] lvl, input logic keep_reg);
        mode_e m;
        case (lvl)
            2'd1:    m = MODE_S1;
            2'd2:    m = MODE_S2;
            default: m = MODE_S3;
        endcase
        if (keep_reg) m = MODE_S4;
        return m;
    endfunction

    function automatic state_e stop_state(input mode_e m);
        case (m)
            MODE_S1: return ST_STOP1;
            MODE_S2: return ST_STOP2;
            MODE_S4: return ST_STOP4;
            default: return ST_STOP3;
        endcase
    endfunction

    function automatic logic is_stop(input state_e s);
        return (s == ST_STOP1) || (s == ST_STOP2) || (s == ST_STOP3) || (s == ST_STOP4);
    endfunction

endpackage

// File: rtl/stop_wake_sync.sv
module stop_wake_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stop_mode_fsm.sv
module stop_mode_fsm
    import stop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic [1:0] req_level,
    input  logic       keep_reg,
    input  logic       dbg_en,
    input  logic       irq_s,
    input  logic       dbgcmd_s,
    input  logic       pin_ack,
    output state_e     state,
    output mode_e      mode_q,
    output mode_e      exit_q,
    output logic       dbg_lat,
    output logic       dbg_cause,
    output logic       pin_hold
);
    logic wake_hit;
    assign wake_hit = irq_s | (dbgcmd_s & dbg_lat);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            mode_q    <= MODE_NONE;
            exit_q    <= MODE_NONE;
            dbg_lat   <= 1'b0;
            dbg_cause <= 1'b0;
            pin_hold  <= 1'b0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (pin_ack) pin_hold <= 1'b0;
                    if (stop_req) begin
                        state   <= ST_ENTER;
                        mode_q  <= resolve_mode(req_level, keep_reg);
                        dbg_lat <= dbg_en;
                    end
                end
                ST_ENTER: begin
                    state <= stop_state(mode_q);
                    if (mode_q == MODE_S2) pin_hold <= 1'b1;
                    if (mode_q == MODE_S1) pin_hold <= 1'b0;
                end
                ST_STOP1, ST_STOP2, ST_STOP3, ST_STOP4: begin
                    if (wake_hit) begin
                        state     <= ST_WAKE;
                        dbg_cause <= dbgcmd_s & dbg_lat;
                    end
                end
                ST_WAKE: begin
                    state     <= ST_RUN;
                    exit_q    <= mode_q;
                    dbg_cause <= 1'b0;
                end
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/stop_out_decode.sv
module stop_out_decode
    import stop_pkg::*;
(
    input  state_e   state,
    input  mode_e    mode_q,
    input  logic     dbg_lat,
    input  logic     dbg_cause,
    input  logic     adc_async_clk,
    input  logic     mfo_need,
    output pm_ctrl_t ctrl
);
    logic stopped;
    logic deep;

    assign stopped = is_stop(state);
    assign deep    = (mode_q == MODE_S1) || (mode_q == MODE_S2);

    always_comb begin
        ctrl               = '0;
        ctrl.reg_standby   = stopped && (mode_q != MODE_S4);
        ctrl.dbg_clk_en    = !stopped || dbg_lat;
        ctrl.periph_clk_en = !stopped;
        ctrl.hfo_en        = !stopped;
        ctrl.mfo_en        = !stopped || mfo_need;
        ctrl.pin_hiz       = (state == ST_STOP1);
        ctrl.adc_abort     = (state == ST_ENTER) && !deep && !adc_async_clk;
        ctrl.sys_reset     = (state == ST_WAKE) && deep;
        ctrl.bkgd_enter    = (state == ST_WAKE) && dbg_cause;
    end
endmodule

// File: rtl/stop_seq_ctrl.sv
module stop_seq_ctrl
    import stop_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic [1:0] req_level,
    input  logic       lvd_en,
    input  logic       lvd_stop_en,
    input  logic       dbg_en,
    input  logic       wake_irq,
    input  logic       wake_dbg,
    input  logic       pin_ack,
    input  logic       adc_async_clk,
    input  logic       mfo_need,
    output logic       in_stop,
    output logic       reg_standby,
    output logic       dbg_clk_en,
    output logic       periph_clk_en,
    output logic       hfo_en,
    output logic       mfo_en,
    output logic       pin_hold,
    output logic       pin_hiz,
    output logic       adc_abort,
    output logic       sys_reset,
    output logic       bkgd_enter,
    output logic [2:0] exit_mode
);
    localparam int NWAKE = 2;

    logic [NWAKE-1:0] wake_s;
    state_e           state;
    mode_e            mode_q;
    mode_e            exit_q;
    logic             dbg_lat;
    logic             dbg_cause;
    pm_ctrl_t         ctrl;
    logic             keep_reg;

    assign keep_reg = (lvd_en & lvd_stop_en) | dbg_en;

    stop_wake_sync #(.W(NWAKE), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wake_dbg, wake_irq}),
        .q   (wake_s)
    );

    stop_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .stop_req  (stop_req),
        .req_level (req_level),
        .keep_reg  (keep_reg),
        .dbg_en    (dbg_en),
        .irq_s     (wake_s[0]),
        .dbgcmd_s  (wake_s[1]),
        .pin_ack   (pin_ack),
        .state     (state),
        .mode_q    (mode_q),
        .exit_q    (exit_q),
        .dbg_lat   (dbg_lat),
        .dbg_cause (dbg_cause),
        .pin_hold  (pin_hold)
    );

    stop_out_decode u_dec (
        .state         (state),
        .mode_q        (mode_q),
        .dbg_lat       (dbg_lat),
        .dbg_cause     (dbg_cause),
        .adc_async_clk (adc_async_clk),
        .mfo_need      (mfo_need),
        .ctrl          (ctrl)
    );

    assign in_stop       = is_stop(state);
    assign reg_standby   = ctrl.reg_standby;
    assign dbg_clk_en    = ctrl.dbg_clk_en;
    assign periph_clk_en = ctrl.periph_clk_en;
    assign hfo_en        = ctrl.hfo_en;
    assign mfo_en        = ctrl.mfo_en;
    assign pin_hiz       = ctrl.pin_hiz;
    assign adc_abort     = ctrl.adc_abort;
    assign sys_reset     = ctrl.sys_reset;
    assign bkgd_enter    = ctrl.bkgd_enter;
    assign exit_mode     = exit_q;
endmodule

// File: rtl/stop_seq_chk.sv
module stop_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_stop,
    input logic       reg_standby,
    input logic       dbg_clk_en,
    input logic       periph_clk_en,
    input logic       hfo_en,
    input logic       pin_hiz,
    input logic       pin_hold,
    input logic       pin_ack,
    input logic       adc_abort,
    input logic       sys_reset,
    input logic       bkgd_enter
);
    AST_STOP_GATES_CLOCKS: assert property (@(posedge clk) disable iff (rst)
        in_stop |-> (!periph_clk_en && !hfo_en)); // R2
    AST_RUN_DEBUG_CLOCK: assert property (@(posedge clk) disable iff (rst)
        !in_stop |-> dbg_clk_en); // R3
    AST_STANDBY_ONLY_STOP: assert property (@(posedge clk) disable iff (rst)
        reg_standby |-> in_stop); // R4
    AST_HIZ_ONLY_STOP: assert property (@(posedge clk) disable iff (rst)
        pin_hiz |-> in_stop); // R5
    AST_HOLD_KEPT_IN_STOP: assert property (@(posedge clk) disable iff (rst)
        (in_stop && pin_hold) |=> pin_hold); // R5
    AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sys_reset |=> !sys_reset); // R6
    AST_BKGD_AFTER_DBG_STOP: assert property (@(posedge clk) disable iff (rst)
        bkgd_enter |-> ($past(in_stop) && $past(dbg_clk_en))); // R7
    AST_ABORT_BEFORE_STOP: assert property (@(posedge clk) disable iff (rst)
        adc_abort |=> (in_stop && !adc_abort)); // R8
endmodule

bind stop_seq_ctrl stop_seq_chk u_chk (.*);

// File: tb/stop_seq_ctrl_tb.sv
module stop_seq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       stop_req, lvd_en, lvd_stop_en, dbg_en, wake_irq, wake_dbg;
    logic       pin_ack, adc_async_clk, mfo_need;
    logic [1:0] req_level;
    logic       in_stop, reg_standby, dbg_clk_en, periph_clk_en, hfo_en, mfo_en;
    logic       pin_hold, pin_hiz, adc_abort, sys_reset, bkgd_enter;
    logic [2:0] exit_mode;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    stop_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .req_level(req_level),
        .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en), .dbg_en(dbg_en),
        .wake_irq(wake_irq), .wake_dbg(wake_dbg), .pin_ack(pin_ack),
        .adc_async_clk(adc_async_clk), .mfo_need(mfo_need),
        .in_stop(in_stop), .reg_standby(reg_standby), .dbg_clk_en(dbg_clk_en),
        .periph_clk_en(periph_clk_en), .hfo_en(hfo_en), .mfo_en(mfo_en),
        .pin_hold(pin_hold), .pin_hiz(pin_hiz), .adc_abort(adc_abort),
        .sys_reset(sys_reset), .bkgd_enter(bkgd_enter), .exit_mode(exit_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic int exp_depth(input logic [1:0] lvl, input logic lvd, input logic lvds, input logic dbg);
        int d;
        d = (lvl == 2'd1) ? 1 : (lvl == 2'd2) ? 2 : 3;
        if ((lvd && lvds) || dbg) d = 4;
        return d;
    endfunction

    task automatic run_stop(input logic [1:0] lvl, input logic lvd, input logic lvds,
                            input logic dbg, input logic adcas, input logic mfo,
                            input logic use_dbg_wake, input logic ack_in_stop);
        int d;
        d = exp_depth(lvl, lvd, lvds, dbg);
        req_level = lvl; lvd_en = lvd; lvd_stop_en = lvds; dbg_en = dbg;
        adc_async_clk = adcas; mfo_need = mfo;
        stop_req = 1'b1;
        step(1);
        stop_req = 1'b0;
        check("R8 abort strobe", adc_abort, (d >= 3 && !adcas) ? 1 : 0);
        check("R2 not yet stopped", in_stop, 0);
        // dbg_en may change after the request without effect on the stop
        dbg_en = ~dbg;
        step(1);
        check("R2 in_stop", in_stop, 1);
        check("R2 periph gated", periph_clk_en, 0);
        check("R2 hfo off", hfo_en, 0);
        check("R3 debug clock", dbg_clk_en, dbg);
        check("R4 standby", reg_standby, (d != 4) ? 1 : 0);
        check("R5 hiz", pin_hiz, (d == 1) ? 1 : 0);
        check("R5 hold on entry", pin_hold, (d == 2) ? 1 : 0);
        check("R9 mfo", mfo_en, mfo);
        check("R8 abort single", adc_abort, 0);
        pin_ack = ack_in_stop;
        if (use_dbg_wake) begin
            wake_dbg = 1'b1;
            if (!dbg) begin
                step(5);
                check("R7 dbg wake ignored", in_stop, 1);
                wake_irq = 1'b1;
            end
        end else begin
            wake_irq = 1'b1;
        end
        step(2);
        check("R7 sync latency", in_stop, 1);
        step(1);
        check("R7 woke", in_stop, 0);
        check("R6 reset pulse", sys_reset, (d <= 2) ? 1 : 0);
        check("R7 bkgd", bkgd_enter, (use_dbg_wake && dbg) ? 1 : 0);
        wake_irq = 1'b0; wake_dbg = 1'b0; pin_ack = 1'b0;
        step(1);
        check("R1 exit depth", exit_mode, d);
        check("R6 reset single", sys_reset, 0);
        check("R2 run clocks", periph_clk_en & hfo_en, 1);
        check("R4 run no standby", reg_standby, 0);
        check("R5 hold after wake", pin_hold, (d == 2) ? 1 : 0);
        if (d == 2) begin
            pin_ack = 1'b1;
            step(1);
            pin_ack = 1'b0;
            check("R5 release", pin_hold, 0);
        end
        step(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h51A7));
        rst = 1'b1; stop_req = 0; req_level = 0; lvd_en = 0; lvd_stop_en = 0;
        dbg_en = 0; wake_irq = 0; wake_dbg = 0; pin_ack = 0; adc_async_clk = 0; mfo_need = 0;
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 reset exit_mode", exit_mode, 0);
        check("R2 reset in_stop", in_stop, 0);
        check("R2 reset clocks", periph_clk_en & hfo_en, 1);
        check("R5 reset hold", pin_hold, 0);
        check("R4 reset standby", reg_standby, 0);

        // directed corners
        run_stop(2'd1, 0, 0, 0, 0, 0, 0, 0);
        run_stop(2'd2, 0, 0, 0, 0, 1, 0, 1);
        run_stop(2'd3, 0, 0, 0, 1, 0, 0, 0);
        run_stop(2'd0, 0, 0, 0, 0, 1, 0, 0);
        run_stop(2'd1, 1, 1, 0, 0, 0, 0, 0);
        run_stop(2'd2, 1, 0, 0, 0, 0, 0, 0);
        run_stop(2'd2, 0, 0, 1, 0, 0, 1, 0);
        run_stop(2'd1, 0, 0, 0, 0, 0, 1, 0);
        run_stop(2'd2, 0, 0, 0, 0, 0, 1, 1);

        // constrained random
        for (int k = 0; k < 60; k++) begin
            logic [1:0] lvl;
            lvl = 2'($urandom_range(0, 3));
            run_stop(lvl, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                     1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule